// File: doc/BRIEF.md
# Delta Sample Fetch Controller

This block pulls a stream of sample bytes out of memory for an audio channel. Software programs a control byte, a start-address byte and a length byte, then sets a channel enable bit. The block then fetches one byte each time a programmable period timer expires. The period is picked from a fixed table of sixteen CPU-cycle counts. Each fetched byte is handed to the channel on a one-cycle valid strobe. Decoding those bytes, driving a DAC and mixing are left to other logic.

The block keeps a current fetch address and a count of bytes still to fetch. At the end of a sample it either starts the same sample again (loop mode) or stops and raises an interrupt if that is enabled. An address that runs past the top of memory carries on at the start of the upper half, not at zero. Every fetch also holds the CPU off the bus for a fixed number of cycles through a stall output. Memory is reached through a request/acknowledge port that allows one request at a time.

Top module: `dsf_fetch`

## Requirements
- R1: After reset, mem_req, cpu_stall and irq are low and a read of the channel register (select 4) returns 0x00.
- R2: The first fetch of a sample is at address 0xC000 + (start byte << 6), where the start byte is written at select 2. Every fetch address lies in 0x8000..0xFFFF.
- R3: A sample is (length byte << 4) bytes long, with the length byte written at select 3. Consecutive fetches use consecutive addresses.
- R4: When the last byte of a sample is fetched with the loop bit (control bit 6, select 0) clear, fetching stops. If the interrupt-enable bit (control bit 7) is set, irq rises; if it is clear, irq stays low.
- R5: Reading select 4 returns bit 4 set while the byte count is nonzero and bit 6 set while an interrupt is pending. That read clears the pending interrupt.
- R6: With rate index k in control bits 3..0, the first request appears exactly P(k) cycles after the enabling write, where P = 428,380,340,320,286,254,226,214,190,160,142,128,106,85,72,54 for k = 0..15.
- R7: Writing select 4 with bit 4 set enables fetching. It reloads the address and count only if the channel was disabled or its count was zero. Writing bit 4 clear stops further requests, and the count is kept.
- R8: mem_req holds with a stable mem_addr until mem_ack. Each acknowledged request moves the address on by one and is followed by a cycle without a request.
- R9: cpu_stall is high whenever mem_req is high. With mem_ack answering at once, each fetch holds cpu_stall high for exactly 4 cycles.
- R10: The address after 0xFFFF is 0x8000.
- R11: With the loop bit set, the address and count reload from the start and length bytes after the last byte, fetching continues and no interrupt is raised.
- R12: A write to the output-level register (select 1) changes neither the status nor the fetch sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of select 4 clears the interrupt |
| reg_sel | input | 3 | Register select: 0 control, 1 level, 2 start, 3 length, 4 channel |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Status byte when select is 4, otherwise zero |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_ack | input | 1 | Memory acknowledge; read data is valid in the same cycle |
| mem_rdata | input | 8 | Memory read data |
| sample_byte | output | 8 | Last fetched byte |
| sample_vld | output | 1 | One-cycle strobe when sample_byte is updated |
| cpu_stall | output | 1 | Holds the CPU off the bus |
| irq | output | 1 | Pending end-of-sample interrupt |

## Verification
The hardest case to reach is the wrap from 0xFFFF to 0x8000. It only happens once a sample has already fetched past the top of memory. The stimulus places the start at 0xFFC0 and sets a length of 80 bytes, so 64 fetches reach the top and 16 more run on from 0x8000. A second hard case is the enable write that arrives while a sample is still running. The bench rewrites the start byte in the middle of a looping sample and sets the enable bit again. The fetch sequence must carry on unchanged until a real disable is followed by a re-enable.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 12;
  localparam int PER_W  = 9;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_LEVEL = 3'd1;
  localparam logic [2:0] SEL_START = 3'd2;
  localparam logic [2:0] SEL_LEN   = 3'd3;
  localparam logic [2:0] SEL_CHAN  = 3'd4;

  // CPU cycles between fetches for each rate index
  function automatic logic [PER_W-1:0] rate_period(input logic [3:0] idx);
    case (idx)
      4'd0:  return 9'd428;
      4'd1:  return 9'd380;
      4'd2:  return 9'd340;
      4'd3:  return 9'd320;
      4'd4:  return 9'd286;
      4'd5:  return 9'd254;
      4'd6:  return 9'd226;
      4'd7:  return 9'd214;
      4'd8:  return 9'd190;
      4'd9:  return 9'd160;
      4'd10: return 9'd142;
      4'd11: return 9'd128;
      4'd12: return 9'd106;
      4'd13: return 9'd85;
      4'd14: return 9'd72;
      default: return 9'd54;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] first_addr(input logic [7:0] r);
    return 16'hC000 + {2'b00, r, 6'b000000};
  endfunction

  function automatic logic [LEN_W-1:0] byte_total(input logic [7:0] r);
    return {r, 4'b0000};
  endfunction

  // Increment that folds an overflow into the upper half
  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return (a == 16'hFFFF) ? 16'h8000 : a + 16'd1;
  endfunction
endpackage

// File: rtl/dsf_regs.sv
module dsf_regs
  import dsf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [2:0] sel,
  input  logic [7:0] wdata,
  output logic       irq_en,
  output logic       loop_en,
  output logic [3:0] rate_idx,
  output logic [7:0] start_reg,
  output logic [7:0] len_reg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en    <= 1'b0;
      loop_en   <= 1'b0;
      rate_idx  <= 4'd0;
      start_reg <= 8'd0;
      len_reg   <= 8'd0;
    end else if (wr) begin
      case (sel)
        SEL_CTRL: begin
          irq_en   <= wdata[7];
          loop_en  <= wdata[6];
          rate_idx <= wdata[3:0];
        end
        SEL_START: start_reg <= wdata;
        SEL_LEN:   len_reg   <= wdata;
        default: ;  // level register and others: accepted, no state
      endcase
    end
  end
endmodule

// File: rtl/dsf_rate_timer.sv
module dsf_rate_timer
  import dsf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [PER_W-1:0] period,
  output logic             expire
);
  logic [PER_W-1:0] tcnt;
  logic             at_end;

  assign at_end = (tcnt == period - 9'd1);
  assign expire = run && !hold && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)         tcnt <= '0;
    else if (!run)      tcnt <= '0;
    else if (expire)    tcnt <= '0;
    else if (!at_end)   tcnt <= tcnt + 9'd1;
  end
endmodule

// File: rtl/dsf_fetch_engine.sv
module dsf_fetch_engine
  import dsf_pkg::*;
#(
  parameter int STALL_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_wr,
  input  logic              chan_on,
  input  logic              status_rd,
  input  logic              irq_en,
  input  logic              loop_en,
  input  logic [7:0]        start_reg,
  input  logic [7:0]        len_reg,
  input  logic              expire,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  output logic              active,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        sample_byte,
  output logic              sample_vld,
  output logic              cpu_stall,
  output logic              irq_pend,
  output logic              bytes_left,
  output logic              byte_done,
  output logic              sample_end
);
  localparam int SC_W = $clog2(STALL_CYCLES + 1);
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(STALL_CYCLES - 1);

  logic              en;
  logic [ADDR_W-1:0] cur;
  logic [LEN_W-1:0]  cnt;
  logic [SC_W-1:0]   scnt;

  assign bytes_left = (cnt != '0);
  assign active     = en && bytes_left;
  assign byte_done  = mem_req && mem_ack;
  assign sample_end = byte_done && (cnt == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en          <= 1'b0;
      cur         <= '0;
      cnt         <= '0;
      mem_req     <= 1'b0;
      mem_addr    <= '0;
      sample_byte <= '0;
      sample_vld  <= 1'b0;
      cpu_stall   <= 1'b0;
      scnt        <= '0;
      irq_pend    <= 1'b0;
    end else begin
      sample_vld <= 1'b0;
      if (status_rd) irq_pend <= 1'b0;

      // stall window and request launch
      if (expire) begin
        mem_req   <= 1'b1;
        mem_addr  <= cur;
        cpu_stall <= 1'b1;
        scnt      <= '0;
      end else if (cpu_stall) begin
        if (scnt != SC_LAST) scnt <= scnt + 1'b1;
        if (scnt == SC_LAST && (!mem_req || mem_ack)) cpu_stall <= 1'b0;
      end

      // completion of a byte
      if (byte_done) begin
        mem_req     <= 1'b0;
        sample_byte <= mem_rdata;
        sample_vld  <= 1'b1;
        cur         <= step_addr(cur);
        cnt         <= cnt - LEN_W'(1);
        if (sample_end) begin
          if (loop_en) begin
            cur <= first_addr(start_reg);
            cnt <= byte_total(len_reg);
          end else begin
            en <= 1'b0;
            if (irq_en) irq_pend <= 1'b1;
          end
        end
      end

      // channel register write
      if (chan_wr) begin
        if (chan_on) begin
          if (!en || !bytes_left) begin
            cur <= first_addr(start_reg);
            cnt <= byte_total(len_reg);
          end
          en <= 1'b1;
        end else begin
          en <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dsf_fetch.sv
module dsf_fetch
  import dsf_pkg::*;
#(
  parameter int STALL_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        mem_req,
  output logic [15:0] mem_addr,
  input  logic        mem_ack,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  sample_byte,
  output logic        sample_vld,
  output logic        cpu_stall,
  output logic        irq
);
  logic             irq_en, loop_en;
  logic [3:0]       rate_idx;
  logic [7:0]       start_reg, len_reg;
  logic             active, expire, bytes_left, byte_done, sample_end;
  logic             chan_wr, status_rd;
  logic [PER_W-1:0] period;

  assign chan_wr   = reg_wr && (reg_sel == SEL_CHAN);
  assign status_rd = reg_rd && (reg_sel == SEL_CHAN);
  assign period    = rate_period(rate_idx);
  assign reg_rdata = (reg_sel == SEL_CHAN) ? {1'b0, irq, 1'b0, bytes_left, 4'b0000} : 8'h00;

  dsf_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .irq_en(irq_en), .loop_en(loop_en), .rate_idx(rate_idx),
    .start_reg(start_reg), .len_reg(len_reg)
  );

  dsf_rate_timer u_timer (
    .clk(clk), .rst_n(rst_n), .run(active), .hold(mem_req),
    .period(period), .expire(expire)
  );

  dsf_fetch_engine #(.STALL_CYCLES(STALL_CYCLES)) u_eng (
    .clk(clk), .rst_n(rst_n), .chan_wr(chan_wr), .chan_on(reg_wdata[4]),
    .status_rd(status_rd), .irq_en(irq_en), .loop_en(loop_en),
    .start_reg(start_reg), .len_reg(len_reg), .expire(expire),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .active(active),
    .mem_req(mem_req), .mem_addr(mem_addr), .sample_byte(sample_byte),
    .sample_vld(sample_vld), .cpu_stall(cpu_stall), .irq_pend(irq),
    .bytes_left(bytes_left), .byte_done(byte_done), .sample_end(sample_end)
  );
endmodule

// File: rtl/dsf_fetch_chk.sv
module dsf_fetch_chk #(
  parameter int STALL_CYCLES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        expire,
  input logic        byte_done,
  input logic        sample_end,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [15:0] mem_addr,
  input logic        cpu_stall,
  input logic        irq
);
  logic [7:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)                  run_len <= '0;
    else if (!cpu_stall)         run_len <= '0;
    else if (run_len != 8'hFF)   run_len <= run_len + 8'd1;
  end

  a_r6_expire_launches: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> mem_req && cpu_stall);

  a_r8_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  a_r8_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !mem_req);

  a_r2_upper_half: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[15]);

  a_r9_stall_covers_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> cpu_stall);

  a_r9_stall_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_stall) |-> run_len >= 8'(STALL_CYCLES));

  a_r4_irq_from_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(sample_end));
endmodule

bind dsf_fetch dsf_fetch_chk #(.STALL_CYCLES(STALL_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .expire(expire), .byte_done(byte_done),
  .sample_end(sample_end), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .cpu_stall(cpu_stall), .irq(irq)
);

// File: tb/test_dsf_fetch.sv
module test_dsf_fetch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        mem_req, mem_ack;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [7:0]  sample_byte;
  logic        sample_vld, cpu_stall, irq;
  logic        ack_block = 1'b0;

  int tests = 0, fails = 0;
  int nfetch = 0;
  logic [15:0] flog [256];

  always #5 clk = ~clk;

  assign mem_ack   = mem_req && !ack_block;
  assign mem_rdata = mem_addr[7:0] ^ 8'h5A;

  dsf_fetch i_dsf_fetch (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .sample_byte(sample_byte), .sample_vld(sample_vld),
    .cpu_stall(cpu_stall), .irq(irq)
  );

  // rate index and expected first-request delay, R6
  localparam logic [12:0] VEC [16] = '{
    {4'd0, 9'd428}, {4'd1, 9'd380}, {4'd2, 9'd340}, {4'd3, 9'd320},
    {4'd4, 9'd286}, {4'd5, 9'd254}, {4'd6, 9'd226}, {4'd7, 9'd214},
    {4'd8, 9'd190}, {4'd9, 9'd160}, {4'd10, 9'd142}, {4'd11, 9'd128},
    {4'd12, 9'd106}, {4'd13, 9'd85}, {4'd14, 9'd72}, {4'd15, 9'd54}
  };

  always @(negedge clk) begin
    if (mem_req && mem_ack) begin
      flog[nfetch[7:0]] = mem_addr;
      nfetch = nfetch + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_status(output logic [7:0] v);
    @(negedge clk);
    reg_sel = 3'd4; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_fetches(input int target, input int limit);
    for (int i = 0; i < limit && nfetch < target; i++) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(3'd4, 8'h00);
    for (int i = 0; i < 20; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] st;
    int n, s, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!mem_req && !cpu_stall && !irq, "R1", {mem_req, cpu_stall, irq}, 0);
    rd_status(st);
    check(st == 8'h00, "R1 status", st, 8'h00);

    // R6 / R9: walk the rate table
    for (int v = 0; v < 16; v++) begin
      wr(3'd0, {4'h0, VEC[v][12:9]});
      wr(3'd2, 8'h00);
      wr(3'd3, 8'h01);
      wr(3'd4, 8'h10);
      n = 0;
      while (!mem_req && n < 1000) begin @(negedge clk); n++; end
      check(n == int'(VEC[v][8:0]), "R6 period", n, int'(VEC[v][8:0]));
      s = 0;
      for (int i = 0; i < 10; i++) begin
        if (cpu_stall) s++;
        @(negedge clk);
      end
      check(s == 4, "R9 stall cycles", s, 4);
      quiesce();
    end

    // R2 R3 R4 R5: one-shot sample with interrupt
    nfetch = 0;
    wr(3'd0, 8'h8F);
    wr(3'd2, 8'h12);
    wr(3'd3, 8'h02);
    wr(3'd4, 8'h10);
    rd_status(st);
    check(st == 8'h10, "R5 bytes remain", st, 8'h10);
    for (int i = 0; i < 4000 && !irq; i++) @(negedge clk);
    check(nfetch == 32, "R3 length", nfetch, 32);
    check(flog[0] == 16'hC480, "R2 start", flog[0], 16'hC480);
    check(flog[31] == 16'hC49F, "R3 last addr", flog[31], 16'hC49F);
    check(irq == 1'b1, "R4 irq", irq, 1);
    rd_status(st);
    check(st == 8'h40, "R5 pending", st, 8'h40);
    check(irq == 1'b0, "R5 read clears", irq, 0);
    rd_status(st);
    check(st == 8'h00, "R5 after clear", st, 8'h00);

    // R4: no interrupt when disabled in control
    nfetch = 0;
    wr(3'd0, 8'h0F);
    wr(3'd3, 8'h01);
    wr(3'd4, 8'h10);
    for (int i = 0; i < 1500; i++) @(negedge clk);
    check(nfetch == 16, "R4 stop count", nfetch, 16);
    check(irq == 1'b0, "R4 no irq", irq, 0);

    // R11 loop, R7 enable semantics, R12 level write
    nfetch = 0;
    wr(3'd0, 8'hCF);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h01);
    wr(3'd4, 8'h10);
    wait_fetches(20, 2000);
    check(flog[16] == 16'hC000, "R11 reload", flog[16], 16'hC000);
    check(flog[15] == 16'hC00F, "R11 last", flog[15], 16'hC00F);
    check(irq == 1'b0, "R11 no irq", irq, 0);
    wr(3'd2, 8'h40);
    wr(3'd4, 8'h10);
    b = nfetch;
    wait_fetches(b + 1, 200);
    check(flog[b[7:0]] == 16'hC000 + 16'(b % 16), "R7 no reload while running",
          flog[b[7:0]], 16'hC000 + 16'(b % 16));
    wr(3'd4, 8'h00);
    for (int i = 0; i < 20; i++) @(negedge clk);
    b = nfetch;
    for (int i = 0; i < 300; i++) @(negedge clk);
    check(nfetch == b, "R7 disable stops", nfetch, b);
    rd_status(st);
    check(st == 8'h10, "R7 count kept", st, 8'h10);
    wr(3'd4, 8'h10);
    wait_fetches(b + 1, 200);
    check(flog[b[7:0]] == 16'hD000, "R7 reload when disabled", flog[b[7:0]], 16'hD000);
    wr(3'd1, 8'hFF);
    rd_status(st);
    check(st == 8'h10, "R12 status", st, 8'h10);
    wait_fetches(b + 2, 200);
    check(flog[8'(b + 1)] == 16'hD001, "R12 sequence", flog[8'(b + 1)], 16'hD001);
    quiesce();

    // R10 wrap
    nfetch = 0;
    wr(3'd0, 8'h0F);
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'h05);
    wr(3'd4, 8'h10);
    wait_fetches(80, 6000);
    for (int i = 0; i < 100; i++) @(negedge clk);
    check(nfetch == 80, "R3 wrap length", nfetch, 80);
    check(flog[63] == 16'hFFFF, "R10 top", flog[63], 16'hFFFF);
    check(flog[64] == 16'h8000, "R10 wrap", flog[64], 16'h8000);
    check(flog[79] == 16'h800F, "R10 after wrap", flog[79], 16'h800F);

    // R8 / R9 slow acknowledge
    ack_block = 1'b1;
    nfetch = 0;
    wr(3'd2, 8'h01);
    wr(3'd3, 8'h01);
    wr(3'd4, 8'h10);
    for (int i = 0; i < 200 && !mem_req; i++) @(negedge clk);
    for (int i = 0; i < 6; i++) @(negedge clk);
    check(mem_req && mem_addr == 16'hC040, "R8 hold", mem_addr, 16'hC040);
    check(cpu_stall == 1'b1, "R9 stall while pending", cpu_stall, 1);
    ack_block = 1'b0;
    @(negedge clk);
    check(!mem_req, "R8 released", mem_req, 0);
    check(sample_vld && sample_byte == (8'h40 ^ 8'h5A), "R8 data", sample_byte, 8'h40 ^ 8'h5A);
    wait_fetches(2, 200);
    check(flog[1] == 16'hC041, "R8 next addr", flog[1], 16'hC041);
    quiesce();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule